// File: doc/BRIEF.md
# Channel-Based Secure Access Bridge

The bridge sits in front of a group of protected peripheral registers. A requester, typically software running without privilege, reaches them only through a small slave window. That window is split into a number of channels. Each channel holds one word-aligned target address. The table of target addresses and the unlock state live behind a separate configuration port, which trusted code owns.

When an access lands in the slave window, the bridge picks the channel from the slave address. If that channel is currently unlocked, the bridge reissues the access on its own master port to the channel's target address. For a read, it returns the target's data and error status to the requester. An unlock is good for one forwarded access only.

If the channel is locked, nothing goes out on the master port. The requester gets an error response, a sticky per-channel flag is set, and the interrupt output rises if it is enabled. Only one transaction is in flight at a time.

Top module: `secure_access_bridge`

## Requirements
- R1: After reset, every channel target address reads 0, every channel is locked, the error flags and the interrupt enable are 0, `irq` is low, `s_req_ready` is high and `m_req_valid` is low.
- R2: A configuration write to byte offset 4*i (i = 0..7) stores the written value as channel i's target address with bits [1:0] forced to 0. A read of the same offset returns that value. Configuration read data appears on `cfg_rdata` one cycle after the read request.
- R3: A configuration write to offset 0x20 unlocks channel `wdata[10:8]` only when `wdata[7:0]` equals 0x55. Any other key value leaves every channel's lock state unchanged. Offset 0x2C reads the unlock state, one bit per channel (bit i = channel i).
- R4: An accepted slave access to an unlocked channel is forwarded once on the master port. The master address is the channel's target address. The write flag, write data and byte strobes are passed through unchanged. Slave address bits [4:2] select the channel.
- R5: For a forwarded access, the master response's read data and error bit are returned unchanged as the slave response.
- R6: A forwarded access relocks its channel, so the next access to that channel is blocked unless the channel is unlocked again.
- R7: An access to a locked channel, read or write, starts no master request. The slave response follows in the cycle after acceptance, with the error bit at 1 and read data 0.
- R8: A blocked access sets bit c of the sticky error flag register at offset 0x28, where c is the blocked channel. Writing 1 to a bit there clears it, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when the interrupt enable (offset 0x24, bit 0) is 1 and at least one error flag is set.
- R10: `s_req_ready` is low from the cycle after acceptance until the cycle after the slave response has been given.
- R11: While `m_req_valid` is high and `m_req_ready` is low, the master request and all of its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Configuration access strobe, single cycle |
| cfg_we | input | 1 | Configuration write (1) or read (0) |
| cfg_addr | input | 6 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, one cycle after the read |
| s_req_valid | input | 1 | Slave request valid |
| s_req_ready | output | 1 | Slave request ready |
| s_req_write | input | 1 | Slave request is a write |
| s_req_addr | input | 8 | Slave window byte address |
| s_req_wdata | input | 32 | Slave write data |
| s_req_wstrb | input | 4 | Slave byte strobes |
| s_rsp_valid | output | 1 | Slave response valid, one-cycle pulse |
| s_rsp_rdata | output | 32 | Slave response read data |
| s_rsp_err | output | 1 | Slave response error |
| m_req_valid | output | 1 | Master request valid |
| m_req_ready | input | 1 | Master request ready |
| m_req_write | output | 1 | Master request is a write |
| m_req_addr | output | 32 | Remapped target address |
| m_req_wdata | output | 32 | Master write data |
| m_req_wstrb | output | 4 | Master byte strobes |
| m_rsp_valid | input | 1 | Master response valid, one-cycle pulse |
| m_rsp_rdata | input | 32 | Master response read data |
| m_rsp_err | input | 1 | Master response error |
| irq | output | 1 | Interrupt request for blocked accesses |

## Verification
Several properties are checked by the assertions on every cycle:
- the request port stalls after each acceptance;
- a pending master request holds steady;
- an access to a locked channel produces an immediate error response and no master request;
- a forwarded access carries the looked-up address;
- a forwarded access relocks its channel;
- a blocked access sets its flag;
- a wrong key changes no lock state.

Other behaviour shows only in the bench's scenarios:
- the configuration register layout and the masking of the low address bits;
- read data and target errors travelling back to the requester;
- the full pattern of sticky flags after a mix of accesses;
- clearing flags by writing ones;
- the interrupt following its enable.

// File: rtl/sab_pkg.sv
package sab_pkg;

  typedef enum logic [1:0] {
    FWD_IDLE = 2'd0,
    FWD_REQ  = 2'd1,
    FWD_WAIT = 2'd2,
    FWD_RESP = 2'd3
  } fwd_state_e;

  // Register word indices above the channel table, relative to the channel count
  localparam int OFS_UNLOCK = 0;
  localparam int OFS_CTRL   = 1;
  localparam int OFS_FLAGS  = 2;
  localparam int OFS_STATUS = 3;

endpackage

// File: rtl/sab_rst_sync.sv
module sab_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/sab_chan_table.sv
module sab_chan_table
  import sab_pkg::*;
#(
  parameter int         N_CH   = 8,
  parameter int         ADDR_W = 32,
  parameter int         DATA_W = 32,
  parameter int         CFG_AW = 6,
  parameter logic [7:0] KEY    = 8'h55
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_en,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic [DATA_W-1:0]        cfg_rdata,
  input  logic [$clog2(N_CH)-1:0]  lookup_ch,
  output logic [ADDR_W-1:0]        lookup_addr,
  output logic                     lookup_unlocked,
  input  logic                     consume,
  input  logic [$clog2(N_CH)-1:0]  consume_ch,
  input  logic                     block_set,
  input  logic [$clog2(N_CH)-1:0]  block_ch,
  output logic                     irq
);

  localparam int CH_W    = $clog2(N_CH);
  localparam int IDX_W   = CFG_AW - 2;
  localparam int IDX_UNL = N_CH + OFS_UNLOCK;
  localparam int IDX_CTL = N_CH + OFS_CTRL;
  localparam int IDX_FLG = N_CH + OFS_FLAGS;
  localparam int IDX_STS = N_CH + OFS_STATUS;

  logic [IDX_W-1:0]  idx;
  logic              wr_en, rd_en;
  logic              key_ok, unl_wr;
  logic [CH_W-1:0]   unl_ch;

  logic [ADDR_W-1:0] tgt_q [N_CH];
  logic [N_CH-1:0]   unl_q, unl_d;
  logic [N_CH-1:0]   flg_q, flg_d;
  logic              ien_q, ien_d, ien_en;
  logic [DATA_W-1:0] rd_q, rd_d;

  assign idx    = cfg_addr[CFG_AW-1:2];
  assign wr_en  = cfg_en & cfg_we;
  assign rd_en  = cfg_en & ~cfg_we;
  assign key_ok = (cfg_wdata[7:0] == KEY);
  assign unl_ch = cfg_wdata[8 +: CH_W];
  assign unl_wr = wr_en && (idx == IDX_W'(IDX_UNL)) && key_ok;

  // Per-channel state: target address, lock bit, sticky error flag
  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    logic              tgt_en;
    logic [ADDR_W-1:0] tgt_r, tgt_nx;
    logic              hit_unl, hit_use, hit_blk, hit_clr;

    assign tgt_en  = wr_en && (idx == IDX_W'(g));
    assign tgt_nx  = {cfg_wdata[ADDR_W-1:2], 2'b00};
    assign hit_unl = unl_wr && (unl_ch == CH_W'(g));
    assign hit_use = consume && (consume_ch == CH_W'(g));
    assign hit_blk = block_set && (block_ch == CH_W'(g));
    assign hit_clr = wr_en && (idx == IDX_W'(IDX_FLG)) && cfg_wdata[g];

    // a new unlock wins over a same-cycle consume; a new block wins over a clear
    assign unl_d[g] = hit_unl ? 1'b1 : (hit_use ? 1'b0 : unl_q[g]);
    assign flg_d[g] = hit_blk ? 1'b1 : (hit_clr ? 1'b0 : flg_q[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgt_r <= '0;
      else if (tgt_en) tgt_r <= tgt_nx;
    end

    assign tgt_q[g] = tgt_r;
  end

  assign ien_en = wr_en && (idx == IDX_W'(IDX_CTL));
  assign ien_d  = cfg_wdata[0];

  always_comb begin
    rd_d = '0;
    if (idx < IDX_W'(N_CH)) begin
      rd_d = DATA_W'(tgt_q[idx[CH_W-1:0]]);
    end else if (idx == IDX_W'(IDX_CTL)) begin
      rd_d = DATA_W'(ien_q);
    end else if (idx == IDX_W'(IDX_FLG)) begin
      rd_d = DATA_W'(flg_q);
    end else if (idx == IDX_W'(IDX_STS)) begin
      rd_d = DATA_W'(unl_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= '0;
      flg_q <= '0;
    end else begin
      unl_q <= unl_d;
      flg_q <= flg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (ien_en) ien_q <= ien_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign cfg_rdata       = rd_q;
  assign lookup_addr     = tgt_q[lookup_ch];
  assign lookup_unlocked = unl_q[lookup_ch];
  assign irq             = ien_q & (|flg_q);

  AST_CONSUME_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    consume && !(unl_wr && unl_ch == consume_ch) |=> !unl_q[$past(consume_ch)]); // R6

  AST_BLOCK_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    block_set |=> flg_q[$past(block_ch)]); // R8

  AST_BAD_KEY_NO_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx == IDX_W'(IDX_UNL) && !key_ok && !consume |=> unl_q == $past(unl_q)); // R3

endmodule

// File: rtl/sab_forward.sv
module sab_forward
  import sab_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_req_valid,
  output logic                     s_req_ready,
  input  logic                     s_req_write,
  input  logic [SADDR_W-1:0]       s_req_addr,
  input  logic [DATA_W-1:0]        s_req_wdata,
  input  logic [DATA_W/8-1:0]      s_req_wstrb,
  output logic                     s_rsp_valid,
  output logic [DATA_W-1:0]        s_rsp_rdata,
  output logic                     s_rsp_err,
  output logic                     m_req_valid,
  input  logic                     m_req_ready,
  output logic                     m_req_write,
  output logic [ADDR_W-1:0]        m_req_addr,
  output logic [DATA_W-1:0]        m_req_wdata,
  output logic [DATA_W/8-1:0]      m_req_wstrb,
  input  logic                     m_rsp_valid,
  input  logic [DATA_W-1:0]        m_rsp_rdata,
  input  logic                     m_rsp_err,
  output logic [$clog2(N_CH)-1:0]  chan_sel,
  input  logic [ADDR_W-1:0]        chan_addr,
  input  logic                     chan_unlocked,
  output logic                     consume,
  output logic                     block_set
);

  localparam int CH_W   = $clog2(N_CH);
  localparam int STRB_W = DATA_W / 8;

  fwd_state_e          st_q, st_d;
  logic                write_q, write_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic [STRB_W-1:0]   wstrb_q, wstrb_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                err_q, err_d;
  logic                accept;
  logic                cap_req, cap_rsp;

  assign chan_sel = s_req_addr[CH_W+1:2];
  assign accept   = s_req_valid && (st_q == FWD_IDLE);

  always_comb begin
    st_d      = st_q;
    write_d   = write_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    wstrb_d   = wstrb_q;
    rdata_d   = rdata_q;
    err_d     = err_q;
    cap_req   = 1'b0;
    cap_rsp   = 1'b0;
    consume   = 1'b0;
    block_set = 1'b0;
    unique case (st_q)
      FWD_IDLE: begin
        if (accept) begin
          cap_req = 1'b1;
          write_d = s_req_write;
          wdata_d = s_req_wdata;
          wstrb_d = s_req_wstrb;
          if (chan_unlocked) begin
            addr_d  = chan_addr;
            consume = 1'b1;
            st_d    = FWD_REQ;
          end else begin
            cap_rsp   = 1'b1;
            rdata_d   = '0;
            err_d     = 1'b1;
            block_set = 1'b1;
            st_d      = FWD_RESP;
          end
        end
      end
      FWD_REQ: begin
        if (m_req_ready) st_d = FWD_WAIT;
      end
      FWD_WAIT: begin
        if (m_rsp_valid) begin
          cap_rsp = 1'b1;
          rdata_d = m_rsp_rdata;
          err_d   = m_rsp_err;
          st_d    = FWD_RESP;
        end
      end
      FWD_RESP: st_d = FWD_IDLE;
      default:  st_d = FWD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FWD_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wstrb_q <= '0;
    end else if (cap_req) begin
      write_q <= write_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      wstrb_q <= wstrb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (cap_rsp) begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign s_req_ready = (st_q == FWD_IDLE);
  assign s_rsp_valid = (st_q == FWD_RESP);
  assign s_rsp_rdata = rdata_q;
  assign s_rsp_err   = err_q;
  assign m_req_valid = (st_q == FWD_REQ);
  assign m_req_write = write_q;
  assign m_req_addr  = addr_q;
  assign m_req_wdata = wdata_q;
  assign m_req_wstrb = wstrb_q;

  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    s_req_valid && s_req_ready |=> !s_req_ready); // R10

  AST_MREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_req_addr) && $stable(m_req_wdata)
      && $stable(m_req_wstrb) && $stable(m_req_write)); // R11

  AST_LOCKED_ERR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !chan_unlocked |=> s_rsp_valid && s_rsp_err && s_rsp_rdata == '0); // R7

  AST_LOCKED_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !chan_unlocked |=> !m_req_valid); // R7

  AST_FWD_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && chan_unlocked |=> m_req_valid && m_req_addr == $past(chan_addr)); // R4

endmodule

// File: rtl/secure_access_bridge.sv
module secure_access_bridge #(
  parameter int         N_CH    = 8,
  parameter int         ADDR_W  = 32,
  parameter int         DATA_W  = 32,
  parameter int         SADDR_W = 8,
  parameter int         CFG_AW  = 6,
  parameter logic [7:0] KEY     = 8'h55
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_en,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     cfg_rdata,
  input  logic                  s_req_valid,
  output logic                  s_req_ready,
  input  logic                  s_req_write,
  input  logic [SADDR_W-1:0]    s_req_addr,
  input  logic [DATA_W-1:0]     s_req_wdata,
  input  logic [DATA_W/8-1:0]   s_req_wstrb,
  output logic                  s_rsp_valid,
  output logic [DATA_W-1:0]     s_rsp_rdata,
  output logic                  s_rsp_err,
  output logic                  m_req_valid,
  input  logic                  m_req_ready,
  output logic                  m_req_write,
  output logic [ADDR_W-1:0]     m_req_addr,
  output logic [DATA_W-1:0]     m_req_wdata,
  output logic [DATA_W/8-1:0]   m_req_wstrb,
  input  logic                  m_rsp_valid,
  input  logic [DATA_W-1:0]     m_rsp_rdata,
  input  logic                  m_rsp_err,
  output logic                  irq
);

  localparam int CH_W = $clog2(N_CH);

  logic              rst_n_i;
  logic [CH_W-1:0]   chan_sel;
  logic [ADDR_W-1:0] chan_addr;
  logic              chan_unlocked;
  logic              consume;
  logic              block_set;

  sab_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  sab_chan_table #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_AW(CFG_AW), .KEY(KEY)
  ) u_table (
    .clk             (clk),
    .rst_n           (rst_n_i),
    .cfg_en          (cfg_en),
    .cfg_we          (cfg_we),
    .cfg_addr        (cfg_addr),
    .cfg_wdata       (cfg_wdata),
    .cfg_rdata       (cfg_rdata),
    .lookup_ch       (chan_sel),
    .lookup_addr     (chan_addr),
    .lookup_unlocked (chan_unlocked),
    .consume         (consume),
    .consume_ch      (chan_sel),
    .block_set       (block_set),
    .block_ch        (chan_sel),
    .irq             (irq)
  );

  sab_forward #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SADDR_W(SADDR_W)
  ) u_fwd (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .s_req_valid   (s_req_valid),
    .s_req_ready   (s_req_ready),
    .s_req_write   (s_req_write),
    .s_req_addr    (s_req_addr),
    .s_req_wdata   (s_req_wdata),
    .s_req_wstrb   (s_req_wstrb),
    .s_rsp_valid   (s_rsp_valid),
    .s_rsp_rdata   (s_rsp_rdata),
    .s_rsp_err     (s_rsp_err),
    .m_req_valid   (m_req_valid),
    .m_req_ready   (m_req_ready),
    .m_req_write   (m_req_write),
    .m_req_addr    (m_req_addr),
    .m_req_wdata   (m_req_wdata),
    .m_req_wstrb   (m_req_wstrb),
    .m_rsp_valid   (m_rsp_valid),
    .m_rsp_rdata   (m_rsp_rdata),
    .m_rsp_err     (m_rsp_err),
    .chan_sel      (chan_sel),
    .chan_addr     (chan_addr),
    .chan_unlocked (chan_unlocked),
    .consume       (consume),
    .block_set     (block_set)
  );

endmodule

// File: tb/secure_access_bridge_test.sv
module secure_access_bridge_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 10;

  // vector: {channel[2:0], write, do_unlock, key[7:0], wdata[31:0]}
  localparam logic [44:0] VEC [NVEC] = '{
    {3'd0, 1'b0, 1'b1, 8'h55, 32'h0000_0000},
    {3'd0, 1'b0, 1'b0, 8'h00, 32'h0000_0000},
    {3'd1, 1'b1, 1'b1, 8'h55, 32'hCAFE_F00D},
    {3'd2, 1'b0, 1'b1, 8'h54, 32'h0000_0000},
    {3'd3, 1'b1, 1'b0, 8'h00, 32'h1111_2222},
    {3'd7, 1'b0, 1'b1, 8'h55, 32'h0000_0000},
    {3'd7, 1'b1, 1'b0, 8'h00, 32'h3333_4449},
    {3'd5, 1'b1, 1'b1, 8'h55, 32'h89AB_CDE3},
    {3'd6, 1'b0, 1'b1, 8'hAA, 32'h0000_0000},
    {3'd4, 1'b0, 1'b1, 8'h55, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_we;
  logic [5:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        s_req_valid, s_req_ready, s_req_write;
  logic [7:0]  s_req_addr;
  logic [31:0] s_req_wdata;
  logic [3:0]  s_req_wstrb;
  logic        s_rsp_valid, s_rsp_err;
  logic [31:0] s_rsp_rdata;
  logic        m_req_valid, m_req_ready, m_req_write;
  logic [31:0] m_req_addr, m_req_wdata;
  logic [3:0]  m_req_wstrb;
  logic        m_rsp_valid, m_rsp_err;
  logic [31:0] m_rsp_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secure_access_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_write(s_req_write),
    .s_req_addr(s_req_addr), .s_req_wdata(s_req_wdata), .s_req_wstrb(s_req_wstrb),
    .s_rsp_valid(s_rsp_valid), .s_rsp_rdata(s_rsp_rdata), .s_rsp_err(s_rsp_err),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_write(m_req_write),
    .m_req_addr(m_req_addr), .m_req_wdata(m_req_wdata), .m_req_wstrb(m_req_wstrb),
    .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata), .m_rsp_err(m_rsp_err),
    .irq(irq)
  );

  function automatic logic [31:0] tgt_of(input logic [2:0] ch);
    return 32'h4000_0010 + {21'd0, ch, 8'd0};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_en = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [5:0] a, output logic [31:0] d);
    cfg_en = 1'b1; cfg_we = 1'b0; cfg_addr = a;
    @(negedge clk);
    cfg_en = 1'b0;
    d = cfg_rdata;
  endtask

  // One slave access; also plays the target on the master port
  task automatic slave_acc(input logic wr, input logic [2:0] ch, input logic [31:0] wd,
                           input logic [3:0] ws, input logic tgt_err,
                           output logic fwd, output logic [31:0] maddr, output logic mwr,
                           output logic [31:0] mwd, output logic [3:0] mws,
                           output logic [31:0] rd, output logic er);
    chk("R10", "ready before request", {31'd0, s_req_ready}, 32'd1);
    s_req_valid = 1'b1; s_req_write = wr; s_req_addr = 8'hA0 | {3'd0, ch, 2'b00};
    s_req_wdata = wd; s_req_wstrb = ws;
    @(negedge clk);
    s_req_valid = 1'b0;
    chk("R10", "ready after accept", {31'd0, s_req_ready}, 32'd0);
    fwd = m_req_valid;
    maddr = m_req_addr; mwr = m_req_write; mwd = m_req_wdata; mws = m_req_wstrb;
    if (fwd) begin
      @(negedge clk);
      chk("R11", "request held", {31'd0, m_req_valid}, 32'd1);
      chk("R11", "address held", m_req_addr, maddr);
      m_req_ready = 1'b1;
      @(negedge clk);
      m_req_ready = 1'b0;
      chk("R10", "ready while waiting", {31'd0, s_req_ready}, 32'd0);
      m_rsp_valid = 1'b1; m_rsp_rdata = ~maddr; m_rsp_err = tgt_err;
      @(negedge clk);
      m_rsp_valid = 1'b0; m_rsp_err = 1'b0;
    end
    chk("R7", "response present", {31'd0, s_rsp_valid}, 32'd1);
    rd = s_rsp_rdata; er = s_rsp_err;
    @(negedge clk);
    chk("R10", "ready after response", {31'd0, s_req_ready}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, maddr, mwd, rd;
    logic [3:0]  mws;
    logic        fwd, mwr, er;
    logic [7:0]  exp_flags;

    rst_n = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    s_req_valid = 1'b0; s_req_write = 1'b0; s_req_addr = '0; s_req_wdata = '0; s_req_wstrb = '0;
    m_req_ready = 1'b0; m_rsp_valid = 1'b0; m_rsp_rdata = '0; m_rsp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "s_req_ready", {31'd0, s_req_ready}, 32'd1);
    chk("R1", "m_req_valid", {31'd0, m_req_valid}, 32'd0);
    chk("R1", "irq", {31'd0, irq}, 32'd0);
    cfg_rd(6'h0C, d); chk("R1", "channel 3 address", d, 32'd0);
    cfg_rd(6'h2C, d); chk("R1", "unlock state", d, 32'd0);
    cfg_rd(6'h28, d); chk("R1", "error flags", d, 32'd0);
    cfg_rd(6'h24, d); chk("R1", "irq enable", d, 32'd0);

    // R2 address masking and readback
    cfg_wr(6'h08, 32'h1234_5677);
    cfg_rd(6'h08, d); chk("R2", "masked address", d, 32'h1234_5674);

    // R3 wrong key leaves locks unchanged, right key unlocks
    cfg_wr(6'h20, 32'h0000_0354);
    cfg_rd(6'h2C, d); chk("R3", "bad key status", d, 32'd0);
    cfg_wr(6'h20, 32'h0000_0355);
    cfg_rd(6'h2C, d); chk("R3", "good key status", d, 32'h0000_0008);
    cfg_wr(6'h20, 32'h0000_0355); // relock-free: still unlocked
    // R5 target error travels back; consume channel 3
    for (int c = 0; c < 8; c++) cfg_wr(6'(c * 4), tgt_of(3'(c)));
    slave_acc(1'b0, 3'd3, 32'd0, 4'h0, 1'b1, fwd, maddr, mwr, mwd, mws, rd, er);
    chk("R5", "target error returned", {31'd0, er}, 32'd1);
    chk("R5", "target data returned", rd, ~tgt_of(3'd3));
    cfg_rd(6'h2C, d); chk("R6", "relocked after use", d, 32'd0);
    cfg_rd(6'h28, d); chk("R8", "target error sets no flag", d, 32'd0);

    // table of vectors
    exp_flags = 8'h00;
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0]  ch;
      logic        wr, unl, exp_fwd;
      logic [7:0]  key;
      logic [31:0] wd;
      {ch, wr, unl, key, wd} = VEC[v];
      exp_fwd = unl && (key == 8'h55);
      if (unl) cfg_wr(6'h20, {21'd0, ch, key});
      slave_acc(wr, ch, wd, wd[3:0], 1'b0, fwd, maddr, mwr, mwd, mws, rd, er);
      chk(exp_fwd ? "R4" : "R7", "forwarded", {31'd0, fwd}, {31'd0, exp_fwd});
      if (exp_fwd) begin
        chk("R4", "remapped address", maddr, tgt_of(ch));
        chk("R4", "write flag", {31'd0, mwr}, {31'd0, wr});
        if (wr) begin
          chk("R4", "write data", mwd, wd);
          chk("R4", "byte strobes", {28'd0, mws}, {28'd0, wd[3:0]});
        end else begin
          chk("R5", "read data", rd, ~tgt_of(ch));
        end
        chk("R5", "error bit", {31'd0, er}, 32'd0);
      end else begin
        exp_flags[ch] = 1'b1;
        chk("R7", "error bit", {31'd0, er}, 32'd1);
        chk("R7", "read data zero", rd, 32'd0);
      end
    end
    cfg_rd(6'h2C, d); chk("R6", "all relocked", d, 32'd0);
    cfg_rd(6'h28, d); chk("R8", "sticky flags", d, {24'd0, exp_flags});
    chk("R9", "irq disabled", {31'd0, irq}, 32'd0);

    // R9 enable, R8 clear by ones
    cfg_wr(6'h24, 32'd1);
    @(negedge clk);
    chk("R9", "irq enabled with flags", {31'd0, irq}, 32'd1);
    cfg_wr(6'h28, 32'h0000_0001);
    cfg_rd(6'h28, d); chk("R8", "partial clear", d, {24'd0, exp_flags & 8'hFE});
    chk("R9", "irq still set", {31'd0, irq}, 32'd1);
    cfg_wr(6'h28, 32'h0000_00FF);
    cfg_rd(6'h28, d); chk("R8", "full clear", d, 32'd0);
    chk("R9", "irq cleared", {31'd0, irq}, 32'd0);
    slave_acc(1'b1, 3'd2, 32'h5, 4'h1, 1'b0, fwd, maddr, mwr, mwd, mws, rd, er);
    chk("R7", "locked write not forwarded", {31'd0, fwd}, 32'd0);
    chk("R9", "irq after new block", {31'd0, irq}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule